// File: doc/BRIEF.md
# Clocked Burst Static RAM

This block is a single-port static RAM that works entirely on one clock. The address, the chip enable, the read/write select, the burst-advance request and the write data are all stored in input registers on a rising edge. The registered request is carried out on the following edge. A read result is registered, so it reaches the read-data bus two edges after the request was presented at the pins.

A built-in two-bit beat counter lets one stored base address drive up to four accesses to neighbouring locations, so the client does not have to present a new address each time. The upper address bits stay fixed during a burst. The low two bits are the base's low bits plus the beat count, taken modulo four, so a burst wraps inside its aligned group of four.

The storage is sized by an address-width parameter and a data-width parameter. The default is 1024 words of 8 bits. A 15-bit address gives a 32K x 8 array.

Top module: `burst_ram_top`

## Requirements
- R1: All inputs are sampled only on the rising clock edge, and the sampled request is carried out on the next rising edge. Outputs and storage change only on rising edges.
- R2: A read request presented before edge N (chipEn=1, writeSel=0) puts the addressed word on rdData and drives rdValid=1 right after edge N+1. rdValid is 1 only in cycles that follow such a carried-out read.
- R3: With chipEn=0 the other inputs have no effect: nothing is written, the beat counter holds, rdValid stays 0 and rdData keeps its last value.
- R4: With chipEn=1 and burstAdv=0, a new base address is loaded from addrIn. The beat counter is cleared, and the access goes to addrIn itself.
- R5: With chipEn=1 and burstAdv=1, the beat counter advances by one. The access goes to the base address with its upper bits unchanged and its low two bits equal to (base low bits + count) mod 4.
- R6: After the fourth beat of a burst, one more advance returns to the first location of the burst.
- R7: A write (chipEn=1, writeSel=1) replaces the word at the access address with the registered wrData. A read leaves the stored contents unchanged.
- R8: Synchronous active-high rst clears rdValid and rdData to 0, and clears the base address and the beat counter to 0. An advance issued straight after reset therefore accesses address 1.
- R9: Any location can be written or read in any order by loading its address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addrIn | input | ADDR_W | Address of a new access |
| chipEn | input | 1 | Request valid; 0 means idle |
| writeSel | input | 1 | 1 = write, 0 = read |
| burstAdv | input | 1 | 1 = next beat of the current burst, 0 = load addrIn |
| wrData | input | DATA_W | Data to be written |
| rdData | output | DATA_W | Registered read data |
| rdValid | output | 1 | rdData holds a fresh read result |

## Verification
The assertions assume that rst is held for at least two cycles before the first request. They also assume that chipEn is low while rst is high, so that a request is never split across a reset. The bench follows both rules at start-up and in its reset in the middle of the run. It fills every location before it issues any read, so every result it compares is a known value rather than an uninitialised word. It drives all inputs half a cycle away from the sampling edge.

// File: rtl/burst_ram_pkg.sv
package burst_ram_pkg;

  localparam int BEAT_W = 2;

  typedef struct packed {
    logic              doWrite;
    logic              doRead;
    logic              loadBase;
    logic              advance;
    logic [BEAT_W-1:0] beatOff;
  } ram_strobe_t;

endpackage

// File: rtl/burst_ram_ctrl.sv
module burst_ram_ctrl
  import burst_ram_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        chipEn,
  input  logic        writeSel,
  input  logic        burstAdv,
  output ram_strobe_t strobe,
  output logic        rdValid
);

  logic              ceQ;
  logic              weQ;
  logic              advQ;
  logic [BEAT_W-1:0] beatCnt;
  logic [BEAT_W-1:0] nextCnt;
  logic              rdValidQ;

  always_comb begin
    strobe.loadBase = ceQ & ~advQ;
    strobe.advance  = ceQ & advQ;
    strobe.doWrite  = ceQ & weQ;
    strobe.doRead   = ceQ & ~weQ;
    if (strobe.loadBase) begin
      nextCnt = '0;
    end else if (strobe.advance) begin
      nextCnt = beatCnt + 1'b1;
    end else begin
      nextCnt = beatCnt;
    end
    strobe.beatOff = nextCnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ceQ      <= 1'b0;
      weQ      <= 1'b0;
      advQ     <= 1'b0;
      beatCnt  <= '0;
      rdValidQ <= 1'b0;
    end else begin
      ceQ      <= chipEn;
      weQ      <= writeSel;
      advQ     <= burstAdv;
      beatCnt  <= nextCnt;
      rdValidQ <= strobe.doRead;
    end
  end

  assign rdValid = rdValidQ;

  AST_VALID_FROM_READ: assert property (@(posedge clk) disable iff (rst)
    rdValid |-> $past(chipEn && !writeSel, 2)); // R2

  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    !chipEn |=> ##1 !rdValid); // R3

  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (chipEn && !burstAdv) |=> ##1 (beatCnt == '0)); // R4

  AST_ADV_STEPS: assert property (@(posedge clk) disable iff (rst)
    (chipEn && burstAdv) |=> ##1 (beatCnt == BEAT_W'($past(beatCnt) + 1'b1))); // R5

endmodule

// File: rtl/burst_ram_dpath.sv
module burst_ram_dpath
  import burst_ram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] wrData,
  input  ram_strobe_t       strobe,
  output logic [DATA_W-1:0] rdData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [ADDR_W-1:0] baseAddr;
  logic [ADDR_W-1:0] srcAddr;
  logic [BEAT_W-1:0] lowBits;
  logic [ADDR_W-1:0] effAddr;
  logic [DATA_W-1:0] rdDataQ;
  logic [DATA_W-1:0] mem [DEPTH];

  always_comb begin
    srcAddr = strobe.loadBase ? addrQ : baseAddr;
    lowBits = srcAddr[BEAT_W-1:0] + strobe.beatOff;
    effAddr = {srcAddr[ADDR_W-1:BEAT_W], lowBits};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ    <= '0;
      dataQ    <= '0;
      baseAddr <= '0;
      rdDataQ  <= '0;
    end else begin
      addrQ <= addrIn;
      dataQ <= wrData;
      if (strobe.loadBase) begin
        baseAddr <= addrQ;
      end
      if (strobe.doRead) begin
        rdDataQ <= mem[effAddr];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && strobe.doWrite) begin
      mem[effAddr] <= dataQ;
    end
  end

  assign rdData = rdDataQ;

  AST_HOLD_WHEN_NO_READ: assert property (@(posedge clk) disable iff (rst)
    !strobe.doRead |=> $stable(rdData)); // R3

endmodule

// File: rtl/burst_ram_top.sv
module burst_ram_top
  import burst_ram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              chipEn,
  input  logic              writeSel,
  input  logic              burstAdv,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  ram_strobe_t strobe;

  burst_ram_ctrl i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .chipEn   (chipEn),
    .writeSel (writeSel),
    .burstAdv (burstAdv),
    .strobe   (strobe),
    .rdValid  (rdValid)
  );

  burst_ram_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) i_dpath (
    .clk    (clk),
    .rst    (rst),
    .addrIn (addrIn),
    .wrData (wrData),
    .strobe (strobe),
    .rdData (rdData)
  );

endmodule

// File: tb/test_burst_ram_top.sv
module test_burst_ram_top;

  localparam int AW    = 10;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addrIn = '0;
  logic          chipEn = 1'b0;
  logic          writeSel = 1'b0;
  logic          burstAdv = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic          rdValid;

  int    total = 0;
  int    bad = 0;
  bit    finished = 1'b0;
  bit    checkOn = 1'b0;
  string phaseTag = "R1 R2";

  always #10 clk = ~clk;

  burst_ram_top #(.ADDR_W(AW), .DATA_W(DW)) i_burst_ram_top (
    .clk      (clk),
    .rst      (rst),
    .addrIn   (addrIn),
    .chipEn   (chipEn),
    .writeSel (writeSel),
    .burstAdv (burstAdv),
    .wrData   (wrData),
    .rdData   (rdData),
    .rdValid  (rdValid)
  );

  // behavioural reference
  logic [DW-1:0] refMem [DEPTH];
  logic          pCe, pWe, pAdv;
  int            pAddr;
  logic [DW-1:0] pWd;
  int            mBase = 0;
  int            mCnt = 0;
  int            mA;
  logic          expValid = 1'b0;
  logic [DW-1:0] expData = '0;

  always @(posedge clk) begin
    if (rst) begin
      pCe = 0; pWe = 0; pAdv = 0; pAddr = 0; pWd = 0;
      mBase = 0; mCnt = 0; expValid = 0; expData = 0;
    end else begin
      expValid = 0;
      if (pCe) begin
        if (!pAdv) begin
          mBase = pAddr;
          mCnt = 0;
        end else begin
          mCnt = (mCnt + 1) % 4;
        end
        mA = (mBase & ~3) | ((mBase + mCnt) & 3);
        if (pWe) refMem[mA] = pWd;
        else begin
          expValid = 1;
          expData = refMem[mA];
        end
      end
      pCe = chipEn; pWe = writeSel; pAdv = burstAdv;
      pAddr = int'(addrIn); pWd = wrData;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (checkOn) begin
      check({phaseTag, " rdValid"}, 32'(rdValid), 32'(expValid));
      check({phaseTag, " R7 rdData"}, 32'(rdData), 32'(expData));
    end
  end

  function automatic logic [DW-1:0] fillVal(int a);
    return DW'(a * 37 + 5);
  endfunction

  task automatic beat(bit ce, bit we, bit adv, int addr, int data);
    @(negedge clk);
    chipEn = ce; writeSel = we; burstAdv = adv;
    addrIn = AW'(addr); wrData = DW'(data);
  endtask

  task automatic readOneExp(int addr, logic [DW-1:0] exp, string tag);
    beat(1, 0, 0, addr, 0);
    beat(0, 0, 0, 0, 0);
    @(negedge clk);
    check({tag, " valid"}, 32'(rdValid), 32'd1);
    check({tag, " data"}, 32'(rdData), 32'(exp));
  endtask

  task automatic burstRead(int base, int nAdv, string tag);
    for (int i = 0; i <= nAdv + 2; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        int k;
        int a;
        k = i - 2;
        a = (base & ~3) | ((base + k) & 3);
        check({tag, " burst valid"}, 32'(rdValid), 32'd1);
        check({tag, " burst data"}, 32'(rdData), 32'(refMem[a]));
      end
      if (i <= nAdv) begin
        chipEn = 1; writeSel = 0; burstAdv = (i != 0); addrIn = AW'(base);
      end else begin
        chipEn = 0; burstAdv = 0;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R9 actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R8: reset state
    check("R8 reset rdValid", 32'(rdValid), 32'd0);
    check("R8 reset rdData", 32'(rdData), 32'd0);
    rst = 0;
    checkOn = 1;

    // fill every location (R7, R9)
    phaseTag = "R7 fill";
    for (int a = 0; a < DEPTH; a++) beat(1, 1, 0, a, int'(fillVal(a)));
    beat(0, 0, 0, 0, 0);
    beat(0, 0, 0, 0, 0);

    phaseTag = "R1 R4";
    readOneExp(5, fillVal(5), "R1 R4 load read");
    readOneExp(DEPTH - 1, fillVal(DEPTH - 1), "R9 top address");

    // burst reads starting mid-group, wrapping (R5, R6)
    phaseTag = "R5 R6";
    burstRead('h1E, 4, "R6 wrap");
    burstRead('h100, 3, "R5 aligned");

    // write burst with wrap overwriting first beat
    phaseTag = "R6 R7";
    beat(1, 1, 0, 'h40, 'hA1);
    beat(1, 1, 1, 'h3FF, 'hB2);
    beat(1, 1, 1, 0, 'hC3);
    beat(1, 1, 1, 0, 'hD4);
    beat(1, 1, 1, 0, 'hE5);
    beat(0, 0, 0, 0, 0);
    beat(0, 0, 0, 0, 0);
    readOneExp('h40, 8'hE5, "R6 wrapped write");
    readOneExp('h41, 8'hB2, "R7 second beat");
    readOneExp('h43, 8'hD4, "R7 fourth beat");
    burstRead('h40, 3, "R7 read back");

    // chip enable low ignores everything (R3)
    phaseTag = "R3";
    for (int i = 0; i < 6; i++) begin
      beat(0, 1, i[0], 'h40, 'hFF);
      if (i >= 2) check("R3 idle rdValid", 32'(rdValid), 32'd0);
    end
    readOneExp('h40, 8'hE5, "R3 no write while idle");

    // idle gap inside a burst keeps the counter (R3, R5)
    beat(1, 0, 0, 'h81, 0);
    beat(1, 0, 1, 0, 0);
    beat(0, 0, 1, 0, 0);
    beat(1, 0, 1, 0, 0);
    beat(0, 0, 0, 0, 0);
    @(negedge clk);
    check("R5 gap burst valid", 32'(rdValid), 32'd1);
    check("R5 gap burst data", 32'(rdData), 32'(fillVal('h83)));

    // reset in the middle of the run (R8)
    phaseTag = "R8";
    beat(0, 0, 0, 0, 0);
    rst = 1;
    @(negedge clk);
    @(negedge clk);
    check("R8 mid reset rdValid", 32'(rdValid), 32'd0);
    check("R8 mid reset rdData", 32'(rdData), 32'd0);
    rst = 0;
    beat(1, 0, 1, 'h200, 0);
    beat(0, 0, 0, 0, 0);
    @(negedge clk);
    check("R8 advance after reset valid", 32'(rdValid), 32'd1);
    check("R8 advance after reset data", 32'(rdData), 32'(fillVal(1)));

    // random traffic against the reference (R9)
    phaseTag = "R9";
    for (int i = 0; i < 3000; i++) begin
      beat(($urandom % 4) != 0, $urandom % 2, $urandom % 2,
           int'($urandom % DEPTH), int'($urandom % 256));
    end
    beat(0, 0, 0, 0, 0);
    beat(0, 0, 0, 0, 0);
    @(negedge clk);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule